// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block sits between a synchronous host and an external asynchronous static RAM of 512K words of 8 bits. The host offers one request at a time on a valid/ready port. Each request is either a single-byte read or a single-byte write. The controller turns it into active-low chip select, output enable and write enable strobes, and holds the 19-bit address steady while the RAM is selected. The data bus is shared between both sides, so the controller splits it into a drive value, a drive enable and a sampled input. A read returns the captured byte together with a valid flag that lasts one cycle.

Every timing interval is a count of clock cycles set by a parameter. The read access is `RD_CYC` cycles. Write address setup is `WR_SETUP`, the write-enable pulse is `WR_PULSE`, and the data/address hold after the strobe is `WR_HOLD`. The bus turnaround after a read is `RD_TURN`. The write is strobed by write enable. Chip select goes low first, write enable falls inside it, and both rise together. The RAM's output drivers therefore never switch on during a write. After every read, the controller stays idle for a number of cycles so that the RAM has released the bus before the controller drives it again. `RD_CYC`, `WR_PULSE` and `RD_TURN` must be at least 1. `WR_SETUP` and `WR_HOLD` may be 0, and a phase with a count of 0 is skipped.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, all three strobes are 1, `sram_dq_oe` is 0 and `rd_valid` is 0.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 for the whole transfer, including any turnaround, and is never 1 while `sram_cs_n` is 0.
- R3: `sram_addr` keeps the accepted address and does not change on any cycle in which `sram_cs_n` is 0 for a second or later consecutive cycle.
- R4: A read holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly `RD_CYC` cycles. The first of these cycles follows the accepting edge. `sram_dq_i` is sampled on the edge that ends the last of them. `rd_valid` is 1 for exactly the one following cycle, with that byte on `rd_data`, so `rd_valid` appears `RD_CYC`+1 cycles after acceptance.
- R5: After a read, at least `RD_TURN` cycles pass with `sram_oe_n`=1 and `sram_dq_oe`=0 before the controller drives the bus. `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R6: A write first holds `sram_cs_n`=0, `sram_we_n`=1 and the data driven for `WR_SETUP` cycles. It then holds `sram_we_n`=0 for exactly `WR_PULSE` cycles. Next, `sram_we_n` and `sram_cs_n` rise together, and data and address are held for `WR_HOLD` more cycles with `sram_dq_oe`=1.
- R7: `sram_we_n` is 0 only while `sram_cs_n` is 0 and `sram_oe_n` is 1.
- R8: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle flag for returned read data |
| rd_data | output | 8 | Captured read byte |
| sram_addr | output | 19 | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_o | output | 8 | Value driven onto the shared data bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | 8 | Value sampled from the shared data bus |

## Verification
The bench builds the block with `RD_CYC`=3, `WR_SETUP`=1, `WR_PULSE`=2, `WR_HOLD`=1 and `RD_TURN`=2. With these values every phase is present, and each phase longer than one cycle actually counts down, so an off-by-one in any phase length shows up as a wrong strobe width. The RAM model in the bench returns a poison byte until its output enable has been low for `RD_CYC` cycles, so a capture taken too early yields wrong data. A write issued directly after a read makes the turnaround gap measurable.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_READ = 3'd1,
    PH_TURN = 3'd2,
    PH_WSET = 3'd3,
    PH_WPUL = 3'd4,
    PH_WHLD = 3'd5
  } phase_e;

  // Number of clock cycles a phase lasts for a given parameter set.
  function automatic int unsigned phase_cycles(phase_e ph, int unsigned rd_cyc,
                                               int unsigned turn_cyc, int unsigned set_cyc,
                                               int unsigned pul_cyc, int unsigned hld_cyc);
    case (ph)
      PH_READ: return rd_cyc;
      PH_TURN: return turn_cyc;
      PH_WSET: return set_cyc;
      PH_WPUL: return pul_cyc;
      PH_WHLD: return hld_cyc;
      default: return 1;
    endcase
  endfunction

  // First write phase: setup is skipped when its count is zero.
  function automatic phase_e write_entry(int unsigned set_cyc);
    return (set_cyc == 0) ? PH_WPUL : PH_WSET;
  endfunction

  // Phase after the write pulse: hold is skipped when its count is zero.
  function automatic phase_e after_pulse(int unsigned hld_cyc);
    return (hld_cyc == 0) ? PH_IDLE : PH_WHLD;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_strobe_pkg::*;
#(
  parameter int unsigned RD_CYC   = 2,
  parameter int unsigned WR_SETUP = 1,
  parameter int unsigned WR_PULSE = 2,
  parameter int unsigned WR_HOLD  = 1,
  parameter int unsigned RD_TURN  = 1,
  parameter int          CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             phase_last,
  output phase_e           phase,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  phase_e nxt;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE: if (req_valid)  nxt = req_write ? write_entry(WR_SETUP) : PH_READ;
      PH_READ: if (phase_last) nxt = PH_TURN;
      PH_TURN: if (phase_last) nxt = PH_IDLE;
      PH_WSET: if (phase_last) nxt = PH_WPUL;
      PH_WPUL: if (phase_last) nxt = after_pulse(WR_HOLD);
      PH_WHLD: if (phase_last) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  assign load     = (nxt != phase);
  assign load_val = CNT_W'(phase_cycles(nxt, RD_CYC, RD_TURN, WR_SETUP, WR_PULSE, WR_HOLD) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/sram_xfer_regs.sv
module sram_xfer_regs #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_i;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int          ADDR_W   = 19,
  parameter int          DATA_W   = 8,
  parameter int unsigned RD_CYC   = 2,
  parameter int unsigned WR_SETUP = 1,
  parameter int unsigned WR_PULSE = 2,
  parameter int unsigned WR_HOLD  = 1,
  parameter int unsigned RD_TURN  = 1,
  parameter int          CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  phase_e           phase;
  logic             phase_last;
  logic             phase_load;
  logic [CNT_W-1:0] phase_load_val;

  // Named internal events
  logic accept_fire;
  logic capture_evt;
  logic in_write;

  assign req_ready   = (phase == PH_IDLE);
  assign accept_fire = req_valid && req_ready;
  assign capture_evt = (phase == PH_READ) && phase_last;
  assign in_write    = (phase == PH_WSET) || (phase == PH_WPUL) || (phase == PH_WHLD);

  sram_seq_fsm #(
    .RD_CYC(RD_CYC), .WR_SETUP(WR_SETUP), .WR_PULSE(WR_PULSE),
    .WR_HOLD(WR_HOLD), .RD_TURN(RD_TURN), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .phase_last(phase_last), .phase(phase), .load(phase_load), .load_val(phase_load_val)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(phase_load), .load_val(phase_load_val), .last(phase_last)
  );

  sram_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept_fire), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(capture_evt), .dq_i(sram_dq_i),
    .addr_q(sram_addr), .wdata_q(sram_dq_o), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Strobes decoded from the registered phase
  assign sram_cs_n  = !((phase == PH_READ) || (phase == PH_WSET) || (phase == PH_WPUL));
  assign sram_oe_n  = (phase != PH_READ);
  assign sram_we_n  = (phase != PH_WPUL);
  assign sram_dq_oe = in_write;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int          ADDR_W   = 19,
  parameter int unsigned RD_CYC   = 2,
  parameter int unsigned WR_PULSE = 2,
  parameter int unsigned RD_TURN  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              sram_cs_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_addr
);
  logic [15:0] oe_run, we_run, quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_run <= '0;
      we_run <= '0;
      quiet  <= 16'hFFFF;
    end else begin
      oe_run <= !sram_oe_n ? oe_run + 1'b1 : '0;
      we_run <= !sram_we_n ? we_run + 1'b1 : '0;
      if (!sram_oe_n)           quiet <= '0;
      else if (quiet != 16'hFFFF) quiet <= quiet + 1'b1;
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> !req_ready); // R2
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && !$past(sram_cs_n)) |-> $stable(sram_addr)); // R3
  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4
  AST_RD_ACCESS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (oe_run == 16'(RD_CYC))); // R4
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R5
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && !$past(sram_dq_oe)) |-> (quiet >= 16'(RD_TURN))); // R5
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_run == 16'(WR_PULSE))); // R6
  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs_n && sram_oe_n)); // R7
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W(ADDR_W), .RD_CYC(RD_CYC), .WR_PULSE(WR_PULSE), .RD_TURN(RD_TURN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
  .sram_dq_oe(sram_dq_oe), .sram_addr(sram_addr)
);

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;
  localparam int RD_CYC = 3, WR_SETUP = 1, WR_PULSE = 2, WR_HOLD = 1, RD_TURN = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0] rd_data, sram_dq_o, sram_dq_i;
  logic [18:0] sram_addr;

  always #4 clk = ~clk;

  sram_strobe_ctrl #(.RD_CYC(RD_CYC), .WR_SETUP(WR_SETUP), .WR_PULSE(WR_PULSE),
                     .WR_HOLD(WR_HOLD), .RD_TURN(RD_TURN)) u_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // RAM model: poison until output enable has been low long enough
  logic [7:0] ram [int];
  int age = 0;
  always @(posedge clk) begin
    if (!sram_cs_n && !sram_we_n) ram[int'(sram_addr)] = sram_dq_o;
    age <= (!sram_cs_n && !sram_oe_n) ? age + 1 : 0;
  end
  always @* begin
    if (!sram_cs_n && !sram_oe_n && sram_we_n && age >= RD_CYC - 1)
      sram_dq_i = ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : 8'h00;
    else
      sram_dq_i = 8'hEE;
  end

  // Scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] ref_mem [int];

  // Monitor
  int cs_run = 0, we_run = 0, hold_run = 0, quiet = 1000;
  logic prev_we_n = 1, prev_dq_oe = 0, prev_cs_low = 0;
  logic [18:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) check(0, "R4", "rd_valid with nothing outstanding", 1, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data === e, "R8", "read data", rd_data, e);
        end
      end
      cs_run = !sram_cs_n ? cs_run + 1 : 0;
      if (!sram_we_n && prev_we_n)
        check(cs_run == WR_SETUP + 1, "R6", "cs low cycles at we fall", cs_run, WR_SETUP + 1);
      if (!sram_we_n) we_run++;
      else if (!prev_we_n) begin
        check(we_run == WR_PULSE, "R6", "we pulse width", we_run, WR_PULSE);
        check(sram_cs_n == 1'b1, "R6", "cs rises with we", sram_cs_n, 1);
        we_run = 0;
      end
      if (sram_dq_oe && sram_we_n && sram_cs_n) hold_run++;
      if (!sram_dq_oe && prev_dq_oe) begin
        check(hold_run == WR_HOLD, "R6", "data hold cycles", hold_run, WR_HOLD);
        hold_run = 0;
      end
      quiet = !sram_oe_n ? 0 : quiet + 1;
      if (sram_dq_oe && !prev_dq_oe)
        check(quiet >= RD_TURN + 1, "R5", "turnaround before drive", quiet, RD_TURN + 1);
      if (sram_dq_oe) check(sram_oe_n == 1'b1, "R5", "drive while oe low", sram_oe_n, 1);
      if (!sram_we_n) check(!sram_cs_n && sram_oe_n, "R7", "we outside cs/oe",
                            {sram_cs_n, sram_oe_n}, 2'b01);
      if (!sram_cs_n) check(!req_ready, "R2", "ready while selected", req_ready, 0);
      if (!sram_cs_n && prev_cs_low)
        check(sram_addr == prev_addr, "R3", "address moved", sram_addr, prev_addr);
      prev_we_n = sram_we_n; prev_dq_oe = sram_dq_oe;
      prev_cs_low = !sram_cs_n; prev_addr = sram_addr;
    end
  end

  task automatic issue(input logic w, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    ref_mem[int'(a)] = d;
    issue(1'b1, a, d);
  endtask

  task automatic do_read(input logic [18:0] a);
    int lat;
    exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
    issue(1'b0, a, 8'h00);
    lat = 1;
    while (!rd_valid && lat < 50) begin @(negedge clk); lat++; end
    check(lat == RD_CYC + 1, "R4", "read latency", lat, RD_CYC + 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({req_ready, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, rd_valid} == 6'b111100,
          "R1", "reset outputs",
          {req_ready, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, rd_valid}, 6'b111100);
    do_write(19'h00000, 8'hA5);
    do_write(19'h7FFFF, 8'h3C);
    do_write(19'h12345, 8'hFF);
    do_write(19'h55555, 8'h00);
    do_read(19'h00000);
    do_read(19'h7FFFF);
    do_read(19'h12345);
    do_read(19'h55555);
    do_read(19'h2AAAA);          // never written
    do_write(19'h12345, 8'h81);  // write right after a read: turnaround R5
    do_read(19'h12345);
    for (int i = 0; i < 6; i++) do_write(19'(i * 19'h0F0F1), 8'(8'h11 * i + 3));
    for (int i = 5; i >= 0; i--) do_read(19'(i * 19'h0F0F1));
    // request held while busy is not taken twice (R2)
    do_write(19'h00100, 8'h5A);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4", "outstanding reads drained", exp_q.size(), 0);
    finish_run();
  end
endmodule